// File: doc/BRIEF.md
# Two-Thread Shared-Pool Register Renamer

This block renames the register operands of decoded instructions for a core that runs two hardware threads at the same time. Each thread owns a private table that maps its 32 logical registers to physical registers. Both threads draw new physical registers from one shared pool. Each cycle the block accepts at most one instruction per thread. The lane index is the thread ID. An instruction carries two logical sources and an optional logical destination.

For an accepted instruction the block returns the physical tags of both sources and a newly allocated physical destination. It also returns the physical register that the destination was mapped to before, so that a later commit can give it back. The commit port returns up to one register per thread per cycle to the pool. A request that needs a destination while none is free is refused through a per-thread stall output. The requester holds the instruction until it is accepted.

The physical file holds one architected set per thread plus a small spare margin: `NUM_LOG*2 + SPARE_REGS` entries, which is 68 by default. Only the spare registers are free after reset, so the pool runs dry after a few renames unless commits return registers.

Top module: `rnm_rename_unit`

## Requirements
- R1: After reset, logical register i of thread t maps to physical tag t*NUM_LOG+i. The free pool holds exactly the tags from 2*NUM_LOG up to the top of the file. No stall and no output valid is asserted while idle.
- R2: An accepted instruction appears on the out_* ports on the rising edge that accepts it, with out_valid high for that thread. Its source tags come from its own thread's table as it stood before this instruction's own destination update.
- R3: The granted destination tag is the lowest-numbered free tag. When both threads are granted in one cycle, thread 0 takes the lowest free tag and thread 1 the next one. Later instructions of the same thread read the new mapping, and the other thread's table is unchanged.
- R4: out_pold gives the mapping that the destination register held just before the rename.
- R5: With no free tag, a valid request with a destination raises ren_stall in the same cycle. It is not accepted, and it changes neither map nor pool.
- R6: With exactly one free tag and both threads requesting a destination, only one thread is granted. Thread 0 wins the first such contest after reset, and the winner alternates on every later contest. Cycles without a contest leave the turn unchanged.
- R7: A valid request without a destination (ren_has_dst=0) is never stalled and allocates nothing.
- R8: A tag presented on cmt_tag[t] with cmt_valid[t]=1 returns to the pool at that clock edge and can be allocated from the next cycle.
- R9: No tag is handed out again before it has been returned through the commit port. The two threads never receive the same tag in one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ren_valid | input | 2 | Per-thread instruction present |
| ren_has_dst | input | 2 | Per-thread instruction writes a destination |
| ren_src_a | input | 2x5 | Per-thread logical source A |
| ren_src_b | input | 2x5 | Per-thread logical source B |
| ren_dst | input | 2x5 | Per-thread logical destination |
| ren_stall | output | 2 | Per-thread request refused this cycle |
| cmt_valid | input | 2 | Commit slot carries a tag to free |
| cmt_tag | input | 2x7 | Physical tag being freed |
| out_valid | output | 2 | Per-thread renamed result present |
| out_has_dst | output | 2 | Result carries a destination |
| out_psrc_a | output | 2x7 | Physical tag of source A |
| out_psrc_b | output | 2x7 | Physical tag of source B |
| out_pdst | output | 2x7 | Newly allocated destination tag |
| out_pold | output | 2x7 | Previous mapping of the destination |

## Verification
ren_stall is combinational and is due in the same cycle as the request. The bench drives requests on the falling edge and reads the stall one time unit later. Rename results are due at the rising edge that accepts the request, so the bench reads them at the next falling edge, just before it drives the following request. A committed tag is allocatable from the cycle after its commit edge. The reference model applies frees only after that cycle's allocations, so an early reuse shows up as a tag mismatch and as a double-allocation error in a separate in-use tracker.

// File: rtl/rnm_pkg.sv
package rnm_pkg;
  localparam int THREADS = 2;

  typedef enum logic {
    TURN_T0 = 1'b0,
    TURN_T1 = 1'b1
  } turn_e;
endpackage

// File: rtl/rnm_map_table.sv
module rnm_map_table #(
  parameter int NUM_LOG = 32,
  parameter int PW      = 7,
  parameter int TID     = 0,
  localparam int LW     = $clog2(NUM_LOG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] rd_a_idx,
  input  logic [LW-1:0] rd_b_idx,
  input  logic [LW-1:0] rd_d_idx,
  output logic [PW-1:0] rd_a_tag,
  output logic [PW-1:0] rd_b_tag,
  output logic [PW-1:0] rd_d_tag,
  input  logic          wr_en,
  input  logic [LW-1:0] wr_idx,
  input  logic [PW-1:0] wr_tag
);
  logic [PW-1:0] map_q [NUM_LOG];
  logic [PW-1:0] map_d [NUM_LOG];

  // reads see the table before this cycle's write
  always_comb begin
    rd_a_tag = map_q[rd_a_idx];
    rd_b_tag = map_q[rd_b_idx];
    rd_d_tag = map_q[rd_d_idx];
  end

  always_comb begin
    map_d = map_q;
    if (wr_en) map_d[wr_idx] = wr_tag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_LOG; i++) map_q[i] <= PW'(TID * NUM_LOG + i);
    end else if (wr_en) begin
      map_q <= map_d;
    end
  end
endmodule

// File: rtl/rnm_free_pool.sv
module rnm_free_pool
  import rnm_pkg::*;
#(
  parameter int NUM_PHYS   = 68,
  parameter int RESET_BUSY = 64,
  localparam int PW        = $clog2(NUM_PHYS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       alloc0_en,
  input  logic                       alloc1_en,
  input  logic [THREADS-1:0]         rel_valid,
  input  logic [THREADS-1:0][PW-1:0] rel_tag,
  output logic [PW-1:0]              pick0,
  output logic [PW-1:0]              pick1,
  output logic                       have_one,
  output logic                       have_two
);
  logic [NUM_PHYS-1:0] free_q;
  logic [NUM_PHYS-1:0] free_d;
  logic                upd_en;

  // lowest and second-lowest free tags
  always_comb begin
    pick0    = '0;
    have_one = 1'b0;
    for (int i = 0; i < NUM_PHYS; i++) begin
      if (free_q[i] && !have_one) begin
        pick0    = PW'(i);
        have_one = 1'b1;
      end
    end
    pick1    = '0;
    have_two = 1'b0;
    for (int i = 0; i < NUM_PHYS; i++) begin
      if (free_q[i] && have_one && (PW'(i) != pick0) && !have_two) begin
        pick1    = PW'(i);
        have_two = 1'b1;
      end
    end
  end

  always_comb begin
    free_d = free_q;
    if (alloc0_en) free_d[pick0] = 1'b0;
    if (alloc1_en) free_d[pick1] = 1'b0;
    for (int k = 0; k < THREADS; k++) begin
      if (rel_valid[k]) free_d[rel_tag[k]] = 1'b1;
    end
    upd_en = alloc0_en | alloc1_en | (|rel_valid);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_PHYS; i++) free_q[i] <= (i >= RESET_BUSY);
    end else if (upd_en) begin
      free_q <= free_d;
    end
  end

  // R9: a tag taken this cycle is busy afterwards
  assert_taken_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc0_en && !(|rel_valid)) |=> !free_q[$past(pick0)]);

  // R9: the second grant never lands without a first one
  assert_pair_order_R9: assert property (@(posedge clk) disable iff (!rst_n)
    alloc1_en |-> (alloc0_en && have_two));
endmodule

// File: rtl/rnm_grant_arb.sv
module rnm_grant_arb
  import rnm_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [THREADS-1:0] want,
  input  logic               have_one,
  input  logic               have_two,
  output logic [THREADS-1:0] grant
);
  turn_e turn_q;
  turn_e turn_d;
  logic  contest;
  logic  turn_en;

  always_comb begin
    contest = want[0] & want[1] & have_one & !have_two;
    grant   = '0;
    if (have_two) begin
      grant = want;
    end else if (have_one) begin
      if (contest) grant = (turn_q == TURN_T0) ? 2'b01 : 2'b10;
      else         grant = want;
    end
    turn_en = contest;
    turn_d  = (turn_q == TURN_T0) ? TURN_T1 : TURN_T0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       turn_q <= TURN_T0;
    else if (turn_en) turn_q <= turn_d;
  end

  // R6: a single free tag never serves two threads
  assert_single_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !have_two |-> $onehot0(grant));

  // R6: a contest is always decided for someone
  assert_contest_served_R6: assert property (@(posedge clk) disable iff (!rst_n)
    contest |-> ($countones(grant) == 1));
endmodule

// File: rtl/rnm_rename_unit.sv
module rnm_rename_unit
  import rnm_pkg::*;
#(
  parameter int NUM_LOG    = 32,
  parameter int SPARE_REGS = 4,
  localparam int NUM_PHYS  = THREADS * NUM_LOG + SPARE_REGS,
  localparam int LW        = $clog2(NUM_LOG),
  localparam int PW        = $clog2(NUM_PHYS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [THREADS-1:0]         ren_valid,
  input  logic [THREADS-1:0]         ren_has_dst,
  input  logic [THREADS-1:0][LW-1:0] ren_src_a,
  input  logic [THREADS-1:0][LW-1:0] ren_src_b,
  input  logic [THREADS-1:0][LW-1:0] ren_dst,
  output logic [THREADS-1:0]         ren_stall,
  input  logic [THREADS-1:0]         cmt_valid,
  input  logic [THREADS-1:0][PW-1:0] cmt_tag,
  output logic [THREADS-1:0]         out_valid,
  output logic [THREADS-1:0]         out_has_dst,
  output logic [THREADS-1:0][PW-1:0] out_psrc_a,
  output logic [THREADS-1:0][PW-1:0] out_psrc_b,
  output logic [THREADS-1:0][PW-1:0] out_pdst,
  output logic [THREADS-1:0][PW-1:0] out_pold
);
  logic [THREADS-1:0]         want;
  logic [THREADS-1:0]         grant;
  logic [THREADS-1:0]         accept;
  logic [PW-1:0]              pick0, pick1;
  logic                       have_one, have_two;
  logic [THREADS-1:0][PW-1:0] new_tag;
  logic [THREADS-1:0][PW-1:0] tag_a, tag_b, tag_old;

  always_comb begin
    want      = ren_valid & ren_has_dst;
    ren_stall = want & ~grant;
    accept    = ren_valid & ~ren_stall;
    new_tag[0] = pick0;
    new_tag[1] = grant[0] ? pick1 : pick0;
  end

  rnm_grant_arb i_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .want     (want),
    .have_one (have_one),
    .have_two (have_two),
    .grant    (grant)
  );

  rnm_free_pool #(
    .NUM_PHYS   (NUM_PHYS),
    .RESET_BUSY (THREADS * NUM_LOG)
  ) i_pool (
    .clk       (clk),
    .rst_n     (rst_n),
    .alloc0_en (|grant),
    .alloc1_en (&grant),
    .rel_valid (cmt_valid),
    .rel_tag   (cmt_tag),
    .pick0     (pick0),
    .pick1     (pick1),
    .have_one  (have_one),
    .have_two  (have_two)
  );

  for (genvar t = 0; t < THREADS; t++) begin : g_thr
    rnm_map_table #(
      .NUM_LOG (NUM_LOG),
      .PW      (PW),
      .TID     (t)
    ) i_map (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_a_idx (ren_src_a[t]),
      .rd_b_idx (ren_src_b[t]),
      .rd_d_idx (ren_dst[t]),
      .rd_a_tag (tag_a[t]),
      .rd_b_tag (tag_b[t]),
      .rd_d_tag (tag_old[t]),
      .wr_en    (grant[t]),
      .wr_idx   (ren_dst[t]),
      .wr_tag   (new_tag[t])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_valid[t] <= 1'b0;
      else        out_valid[t] <= accept[t];
    end

    always_ff @(posedge clk) begin
      if (accept[t]) begin
        out_has_dst[t] <= ren_has_dst[t];
        out_psrc_a[t]  <= tag_a[t];
        out_psrc_b[t]  <= tag_b[t];
        out_pdst[t]    <= new_tag[t];
        out_pold[t]    <= tag_old[t];
      end
    end

    // R5: an empty pool refuses every destination request
    assert_stall_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ren_valid[t] && ren_has_dst[t] && !have_one) |-> ren_stall[t]);

    // R7: requests without a destination pass
    assert_nodst_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ren_valid[t] && !ren_has_dst[t]) |-> !ren_stall[t]);
  end

  // R9: one cycle never hands the same tag to both threads
  assert_distinct_tags_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (&(out_valid & out_has_dst)) |-> (out_pdst[0] != out_pdst[1]));

  // R3: thread 0 holds the lower tag of a pair
  assert_pair_low_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (&(out_valid & out_has_dst)) |-> (out_pdst[0] < out_pdst[1]));
endmodule

// File: tb/test_rnm_rename_unit.sv
module test_rnm_rename_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 32;
  localparam int NP = 2 * NL + 4;
  localparam int LW = 5;
  localparam int PW = 7;

  logic clk = 1'b0;
  logic rst_n;
  logic [1:0]         ren_valid, ren_has_dst, ren_stall;
  logic [1:0][LW-1:0] ren_src_a, ren_src_b, ren_dst;
  logic [1:0]         cmt_valid;
  logic [1:0][PW-1:0] cmt_tag;
  logic [1:0]         out_valid, out_has_dst;
  logic [1:0][PW-1:0] out_psrc_a, out_psrc_b, out_pdst, out_pold;

  rnm_rename_unit i_rnm_rename_unit (
    .clk(clk), .rst_n(rst_n),
    .ren_valid(ren_valid), .ren_has_dst(ren_has_dst),
    .ren_src_a(ren_src_a), .ren_src_b(ren_src_b), .ren_dst(ren_dst),
    .ren_stall(ren_stall),
    .cmt_valid(cmt_valid), .cmt_tag(cmt_tag),
    .out_valid(out_valid), .out_has_dst(out_has_dst),
    .out_psrc_a(out_psrc_a), .out_psrc_b(out_psrc_b),
    .out_pdst(out_pdst), .out_pold(out_pold)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // reference state
  int ref_map [2][NL];
  bit ref_free [NP];
  bit in_use [NP];
  int turn;
  int pend [$];
  bit exp_v [2];
  bit exp_hd [2];
  int exp_a [2], exp_b [2], exp_d [2], exp_old [2];
  string dst_tag = "R3";
  string src_tag = "R2";
  int lcg = 12345;

  function automatic int rnd(int m);
    lcg = lcg * 1103515245 + 12345;
    return ((lcg >>> 8) & 32'h7fffff) % m;
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int t = 0; t < 2; t++)
      for (int i = 0; i < NL; i++) ref_map[t][i] = t * NL + i;
    for (int i = 0; i < NP; i++) begin
      ref_free[i] = (i >= 2 * NL);
      in_use[i]   = (i < 2 * NL);
    end
    turn = 0;
    pend.delete();
  endtask

  // one clock: inputs already driven at a falling edge
  task automatic cycle();
    int nfree, p0, p1;
    bit want [2];
    bit g [2];
    bit contest;
    nfree = 0; p0 = -1; p1 = -1;
    for (int i = 0; i < NP; i++) if (ref_free[i]) begin
      if (p0 < 0) p0 = i; else if (p1 < 0) p1 = i;
      nfree++;
    end
    for (int t = 0; t < 2; t++) begin
      want[t] = ren_valid[t] && ren_has_dst[t];
      g[t] = 0;
    end
    contest = want[0] && want[1] && nfree == 1;
    if (nfree >= 2) begin g[0] = want[0]; g[1] = want[1]; end
    else if (nfree == 1) begin
      if (contest) g[turn] = 1;
      else begin g[0] = want[0]; g[1] = want[1]; end
    end
    #1;
    for (int t = 0; t < 2; t++) begin
      string tg;
      if (ren_valid[t] && !ren_has_dst[t]) tg = "R7";
      else if (contest) tg = "R6";
      else tg = "R5";
      chk(tg, $sformatf("stall t%0d", t), int'(ren_stall[t]), int'(want[t] && !g[t]));
    end
    @(posedge clk);
    for (int t = 0; t < 2; t++) begin
      exp_v[t] = ren_valid[t] && !(want[t] && !g[t]);
      exp_hd[t] = ren_has_dst[t];
      if (exp_v[t]) begin
        exp_a[t] = ref_map[t][ren_src_a[t]];
        exp_b[t] = ref_map[t][ren_src_b[t]];
        if (g[t]) begin
          exp_d[t] = (t == 1 && g[0]) ? p1 : p0;
          exp_old[t] = ref_map[t][ren_dst[t]];
          ref_map[t][ren_dst[t]] = exp_d[t];
          ref_free[exp_d[t]] = 0;
          pend.push_back(exp_old[t]);
        end
      end
    end
    for (int k = 0; k < 2; k++) if (cmt_valid[k]) begin
      ref_free[cmt_tag[k]] = 1;
      in_use[cmt_tag[k]] = 0;
    end
    if (contest) turn = 1 - turn;
    @(negedge clk);
    for (int t = 0; t < 2; t++) begin
      chk(src_tag, $sformatf("out_valid t%0d", t), int'(out_valid[t]), int'(exp_v[t]));
      if (exp_v[t] && out_valid[t]) begin
        chk(src_tag, $sformatf("src_a t%0d", t), int'(out_psrc_a[t]), exp_a[t]);
        chk(src_tag, $sformatf("src_b t%0d", t), int'(out_psrc_b[t]), exp_b[t]);
        if (exp_hd[t]) begin
          chk(dst_tag, $sformatf("pdst t%0d", t), int'(out_pdst[t]), exp_d[t]);
          chk("R4", $sformatf("pold t%0d", t), int'(out_pold[t]), exp_old[t]);
          chk("R9", $sformatf("tag %0d reused while busy", out_pdst[t]),
              int'(in_use[out_pdst[t]]), 0);
          in_use[out_pdst[t]] = 1;
        end
      end
    end
    cmt_valid = '0;
  endtask

  task automatic set_req(int t, bit v, bit hd, int a, int b, int d);
    ren_valid[t] = v; ren_has_dst[t] = hd;
    ren_src_a[t] = LW'(a); ren_src_b[t] = LW'(b); ren_dst[t] = LW'(d);
  endtask

  task automatic commit_one(int k);
    if (pend.size() > 0) begin
      cmt_valid[k] = 1'b1;
      cmt_tag[k] = PW'(pend.pop_front());
    end
  endtask

  initial begin
    rst_n = 1'b0;
    ren_valid = '0; ren_has_dst = '0;
    ren_src_a = '0; ren_src_b = '0; ren_dst = '0;
    cmt_valid = '0; cmt_tag = '0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: idle state after reset
    chk("R1", "out_valid idle", int'(out_valid), 0);
    chk("R1", "stall idle", int'(ren_stall), 0);

    // R1: reset mapping through source reads, no destinations
    src_tag = "R1";
    set_req(0, 1, 0, 3, 31, 0);
    set_req(1, 1, 0, 0, 5, 0);
    cycle();
    chk("R1", "t1 reg5 maps to 37", int'(out_psrc_b[1]), 37);
    src_tag = "R2";

    // R2/R3: same register as source and destination, then reread
    set_req(0, 1, 1, 7, 7, 7);
    set_req(1, 1, 1, 7, 2, 7);
    cycle();
    chk("R3", "t0 gets lowest spare", int'(out_pdst[0]), 64);
    chk("R2", "t0 src reads old map", int'(out_psrc_a[0]), 7);
    set_req(0, 1, 0, 7, 1, 0);
    set_req(1, 1, 0, 7, 1, 0);
    cycle();
    chk("R3", "t0 sees new name", int'(out_psrc_a[0]), 64);
    chk("R3", "t1 sees its own name", int'(out_psrc_a[1]), 65);

    // R5/R7: exhaust the pool without commits
    set_req(0, 1, 1, 1, 2, 3);
    set_req(1, 1, 1, 4, 5, 6);
    cycle();
    cycle();
    set_req(1, 1, 0, 9, 10, 0);
    cycle();
    set_req(1, 1, 1, 4, 5, 8);
    cycle();

    // R6/R8: one tag per cycle back while both threads ask
    dst_tag = "R8";
    for (int n = 0; n < 6; n++) begin
      commit_one(n % 2);
      set_req(0, 1, 1, n, n + 1, n + 2);
      set_req(1, 1, 1, n + 3, n + 4, n + 5);
      cycle();
    end
    dst_tag = "R3";

    // mixed traffic
    for (int n = 0; n < 4000; n++) begin
      for (int t = 0; t < 2; t++)
        set_req(t, rnd(4) != 0, rnd(4) != 0, rnd(NL), rnd(NL), rnd(NL));
      if (rnd(3) != 0) commit_one(0);
      if (rnd(2) != 0) commit_one(1);
      cycle();
    end
    ren_valid = '0;
    cycle();

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++;
      $display("FAIL R9 watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule